// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block gathers the interrupt sources of a synchronous serial port that has transmit and receive FIFOs and a DMA path, and it turns them into one status word and one interrupt line. There are two kinds of source. Five are one-cycle event pulses: receive overrun, receive timeout, receive DMA complete, transmit DMA complete, and last bit shifted out. Each pulse sets a sticky bit that stays set until software clears it. The other two sources are the FIFO fill levels. Each level is compared against the half-depth threshold, and the result goes straight into the status word without being latched.

Software uses a small word-addressed register bus. An enable mask selects which sources can raise the interrupt. The raw status word shows every source whatever the mask holds. The masked status word is the raw word ANDed with the mask. The interrupt line is high whenever any masked bit is set. Writing a 1 to a clear bit acknowledges a sticky event.

Top module: `sport_irq_status`

## Requirements
- R1: After synchronous reset the mask register reads 0, every sticky bit is 0, the masked status reads 0 and `irq` is 0.
- R2: The status bit positions are fixed: bit 0 receive overrun, bit 1 receive timeout, bit 2 receive FIFO level, bit 3 transmit FIFO level, bit 4 receive DMA done, bit 5 transmit DMA done, bit 6 end of transmit. The register addresses are 0 mask, 1 raw status, 2 masked status and 3 clear. The clear register reads 0.
- R3: An event pulse sampled at a rising clock edge sets its raw status bit from the next cycle on. The bit then stays set for any number of cycles until it is cleared.
- R4: Writing 1 to a bit of the clear register clears that sticky bit. Writing 0 to a clear bit has no effect. Writing 1 to clear bit 2 or clear bit 3 is ignored.
- R5: If an event and a clear write for the same bit occur at the same edge, the bit is set after that edge.
- R6: Raw bit 2 is 1 exactly while `rx_fill` is at least FIFO_DEPTH/2, and it follows `rx_fill` with no clear needed.
- R7: Raw bit 3 is 1 exactly while `tx_fill` is at most FIFO_DEPTH/2, and it follows `tx_fill` with no clear needed.
- R8: The masked status equals raw status AND mask, and `irq` is the OR of all masked status bits.
- R9: A write to the raw status or masked status address changes neither register nor the mask.
- R10: Bits 31 to 7 of every register read as 0, including after the mask is written with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_rx_ovr | input | 1 | Receive FIFO overflow pulse |
| evt_rx_tmo | input | 1 | Receive timeout pulse |
| evt_rxdma | input | 1 | Receive DMA complete pulse |
| evt_txdma | input | 1 | Transmit DMA complete pulse |
| evt_tx_end | input | 1 | Last data bit shifted out pulse |
| rx_fill | input | 4 | Receive FIFO occupancy, 0 to FIFO_DEPTH |
| tx_fill | input | 4 | Transmit FIFO occupancy, 0 to FIFO_DEPTH |
| irq | output | 1 | Combined interrupt |

## Verification
A new event and the software acknowledge of that same event can land on the same clock edge. The bench provokes this by raising a timeout pulse and a clear write with bit 1 set in a single drive cycle. It does this once with the bit already set and once with the bit clear. In both cases the bit must still read 1 afterwards and `irq` must stay high. A separate clear write afterwards must then bring the bit down, which shows that the earlier result was not a stuck bit.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

    localparam int NSRC   = 7;
    localparam int DATA_W = 32;

    // Source positions in every status word
    localparam int B_RX_OVR = 0;
    localparam int B_RX_TMO = 1;
    localparam int B_RX_LVL = 2;
    localparam int B_TX_LVL = 3;
    localparam int B_RXDMA  = 4;
    localparam int B_TXDMA  = 5;
    localparam int B_TX_END = 6;

    typedef struct packed {
        logic tx_end;
        logic txdma;
        logic rxdma;
        logic tx_lvl;
        logic rx_lvl;
        logic rx_tmo;
        logic rx_ovr;
    } irq_vec_t;

    typedef enum logic [1:0] {
        RA_MASK  = 2'd0,
        RA_RAW   = 2'd1,
        RA_MSTAT = 2'd2,
        RA_CLR   = 2'd3
    } reg_addr_e;

    // Bits backed by a sticky flop (the rest follow a level)
    localparam logic [NSRC-1:0] STICKY_BITS = 7'b111_0011;

    function automatic logic [DATA_W-1:0] zext(input logic [NSRC-1:0] v);
        return {{(DATA_W-NSRC){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sport_irq_sticky.sv
module sport_irq_sticky
    import sport_irq_pkg::*;
#(
    parameter int N = NSRC,
    parameter logic [N-1:0] KEEP = STICKY_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (KEEP[i]) begin : g_flop
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (set_i[i]) q <= 1'b1;   // event wins over clear
                else if (clr_i[i]) q <= 1'b0;
            end
            assign q_o[i] = q;
        end else begin : g_none
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sport_irq_level.sv
module sport_irq_level #(
    parameter int DEPTH  = 8,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] tx_fill,
    output logic              rx_hi,
    output logic              tx_lo
);
    localparam int HALF = DEPTH / 2;
    localparam logic [FILL_W-1:0] HALF_V = FILL_W'(HALF);

    always_comb begin
        rx_hi = (rx_fill >= HALF_V);
        tx_lo = (tx_fill <= HALF_V);
    end
endmodule

// File: rtl/sport_irq_regs.sv
module sport_irq_regs
    import sport_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_addr_e         addr,
    input  logic [NSRC-1:0]   wdata,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   masked,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   clr_vec,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)                       mask_q <= '0;
        else if (wr && addr == RA_MASK) mask_q <= wdata;
    end

    always_comb begin
        clr_vec = '0;
        if (wr && addr == RA_CLR) clr_vec = wdata & STICKY_BITS;
    end

    always_comb begin
        unique case (addr)
            RA_MASK:  rdata = zext(mask_q);
            RA_RAW:   rdata = zext(raw);
            RA_MSTAT: rdata = zext(masked);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/sport_irq_status.sv
module sport_irq_status
    import sport_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_rx_ovr,
    input  logic              evt_rx_tmo,
    input  logic              evt_rxdma,
    input  logic              evt_txdma,
    input  logic              evt_tx_end,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] tx_fill,
    output logic              irq
);
    irq_vec_t        evt_s, lvl_s;
    logic [NSRC-1:0] evt_vec, lvl_vec, sticky_q, raw, mask_q, masked, clr_vec;
    logic            rx_hi, tx_lo;

    always_comb begin
        evt_s        = '0;
        evt_s.rx_ovr = evt_rx_ovr;
        evt_s.rx_tmo = evt_rx_tmo;
        evt_s.rxdma  = evt_rxdma;
        evt_s.txdma  = evt_txdma;
        evt_s.tx_end = evt_tx_end;
        lvl_s        = '0;
        lvl_s.rx_lvl = rx_hi;
        lvl_s.tx_lvl = tx_lo;
    end
    assign evt_vec = evt_s;
    assign lvl_vec = lvl_s;

    sport_irq_level #(.DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_lvl (
        .rx_fill (rx_fill),
        .tx_fill (tx_fill),
        .rx_hi   (rx_hi),
        .tx_lo   (tx_lo)
    );

    sport_irq_sticky #(.N(NSRC), .KEEP(STICKY_BITS)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_vec),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    assign raw    = sticky_q | lvl_vec;
    assign masked = raw & mask_q;
    assign irq    = |masked;

    sport_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (reg_addr_e'(bus_addr)),
        .wdata   (bus_wdata[NSRC-1:0]),
        .raw     (raw),
        .masked  (masked),
        .mask_q  (mask_q),
        .clr_vec (clr_vec),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/sport_irq_status_chk.sv
module sport_irq_status_chk
    import sport_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   evt_vec,
    input logic [NSRC-1:0]   lvl_vec,
    input logic [NSRC-1:0]   sticky_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq
);
    logic clr_wr, mask_wr;
    assign clr_wr  = bus_wr && bus_addr == 2'd3;
    assign mask_wr = bus_wr && bus_addr == 2'd0;

    // R1: mask is zero after reset, so no interrupt in the first cycle
    a_r1_irq_low_after_reset: assert property (@(posedge clk) rst |=> !irq);

    // R3 and R5: every event leaves its sticky bit set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        (|(evt_vec & STICKY_BITS)) |=> ((sticky_q & $past(evt_vec & STICKY_BITS)) == $past(evt_vec & STICKY_BITS)));

    // R4: a cleared bit without a competing event is zero afterwards
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((sticky_q & $past(bus_wdata[NSRC-1:0] & ~evt_vec & STICKY_BITS)) == '0));

    // R4: sticky bits never rise without an event
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sticky_q & ~$past(sticky_q) & ~$past(evt_vec)) == '0));

    // R8: combined interrupt matches raw sources gated by the mask
    a_r8_irq_is_or: assert property (@(posedge clk) disable iff (rst)
        irq == |((sticky_q | lvl_vec) & mask_q));

    // R9: mask only moves on a write to its own address
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));

    // R10: upper read bits are always zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NSRC] == '0);
endmodule

bind sport_irq_status sport_irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_vec   (evt_vec),
    .lvl_vec   (lvl_vec),
    .sticky_q  (sticky_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/sim_sport_irq_status.sv
`timescale 1ns/1ps
module sim_sport_irq_status;
    localparam int DEPTH = 8;
    localparam int FW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_ovr = 0, ev_tmo = 0, ev_rxd = 0, ev_txd = 0, ev_end = 0;
    logic [FW-1:0] rx_fill = '0;
    logic [FW-1:0] tx_fill = 4'd8;
    logic        irq;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;   // 250 MHz

    sport_irq_status #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rx_ovr(ev_ovr), .evt_rx_tmo(ev_tmo), .evt_rxdma(ev_rxd),
        .evt_txdma(ev_txd), .evt_tx_end(ev_end),
        .rx_fill(rx_fill), .tx_fill(tx_fill), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk);
        #0.5;
        chk(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // drive one cycle of event pulses, bit order as in the status word
    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        ev_ovr = e[0]; ev_tmo = e[1]; ev_rxd = e[4]; ev_txd = e[5]; ev_end = e[6];
        @(negedge clk);
        {ev_ovr, ev_tmo, ev_rxd, ev_txd, ev_end} = '0;
    endtask

    task automatic t_reset;
        rd(2'd0, "R1 mask", 32'h0);
        rd(2'd1, "R1 raw", 32'h0);
        rd(2'd2, "R1 masked", 32'h0);
        chk_irq("R1 irq", 1'b0);
        rd(2'd3, "R2 clear reads zero", 32'h0);
    endtask

    task automatic t_sticky;
        wr(2'd0, 32'h7F);
        pulse(7'h01);
        rd(2'd2, "R3 overrun set", 32'h01);
        chk_irq("R8 irq high", 1'b1);
        repeat (10) @(negedge clk);
        rd(2'd1, "R3 overrun held", 32'h01);
    endtask

    task automatic t_clear;
        wr(2'd3, 32'h0);
        rd(2'd1, "R4 zero write no effect", 32'h01);
        wr(2'd3, 32'h7E);
        rd(2'd1, "R4 other bits no effect", 32'h01);
        wr(2'd3, 32'h01);
        rd(2'd1, "R4 cleared", 32'h0);
        chk_irq("R8 irq low after clear", 1'b0);
    endtask

    task automatic t_map;
        for (int i = 0; i < 7; i++) begin
            if (i == 2 || i == 3) continue;
            pulse(7'(1 << i));
            rd(2'd2, $sformatf("R2 bit %0d position", i), 32'(1 << i));
            wr(2'd3, 32'(1 << i));
            rd(2'd2, $sformatf("R4 bit %0d cleared", i), 32'h0);
        end
    endtask

    task automatic t_same;
        // fresh bit: event and clear together
        @(negedge clk);
        ev_tmo = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h02;
        @(negedge clk);
        ev_tmo = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd1, "R5 event wins from clear", 32'h02);
        // already set
        @(negedge clk);
        ev_tmo = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h02;
        @(negedge clk);
        ev_tmo = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd1, "R5 event wins while set", 32'h02);
        chk_irq("R5 irq stays", 1'b1);
        wr(2'd3, 32'h02);
        rd(2'd1, "R5 later clear works", 32'h0);
    endtask

    task automatic t_levels;
        @(negedge clk); rx_fill = 4'd3;
        rd(2'd1, "R6 rx below half", 32'h0);
        @(negedge clk); rx_fill = 4'd4;
        rd(2'd1, "R6 rx at half", 32'h04);
        chk_irq("R6 rx irq", 1'b1);
        wr(2'd3, 32'h0C);
        rd(2'd1, "R4 level clear ignored", 32'h04);
        @(negedge clk); rx_fill = 4'd8;
        rd(2'd1, "R6 rx full", 32'h04);
        @(negedge clk); rx_fill = 4'd3;
        rd(2'd1, "R6 rx drops itself", 32'h0);
        @(negedge clk); tx_fill = 4'd5;
        rd(2'd1, "R7 tx above half", 32'h0);
        @(negedge clk); tx_fill = 4'd4;
        rd(2'd1, "R7 tx at half", 32'h08);
        @(negedge clk); tx_fill = 4'd0;
        rd(2'd2, "R7 tx empty", 32'h08);
        @(negedge clk); tx_fill = 4'd6;
        rd(2'd1, "R7 tx drops itself", 32'h0);
    endtask

    task automatic t_mask;
        wr(2'd0, 32'h0);
        pulse(7'h30);
        rd(2'd1, "R8 raw when masked", 32'h30);
        rd(2'd2, "R8 masked off", 32'h0);
        chk_irq("R8 irq off when masked", 1'b0);
        wr(2'd0, 32'h20);
        rd(2'd2, "R8 partial mask", 32'h20);
        chk_irq("R8 irq partial", 1'b1);
        wr(2'd3, 32'h30);
    endtask

    task automatic t_readonly;
        pulse(7'h40);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0);
        rd(2'd0, "R9 mask untouched", 32'h20);
        rd(2'd1, "R9 raw untouched", 32'h40);
        rd(2'd2, "R9 masked untouched", 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, "R10 mask upper zero", 32'h7F);
        rd(2'd2, "R10 masked upper zero", 32'h40);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, "R4 clear all", 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_sticky;
        t_clear;
        t_map;
        t_same;
        t_levels;
        t_mask;
        t_readonly;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule